// File: doc/BRIEF.md
# Sample Averaging and Offset Correction Stage

This stage sits directly behind a converter core and post-processes its raw output codes. Each raw sample arrives as a 16-bit full-scale code with a one-cycle valid strobe. The stage can sum a programmable number of consecutive samples (4, 8, 16 or 32) and produce their rounded mean. Averaging can also be switched off, in which case every sample passes straight through.

Each final value has a signed 16-bit correction subtracted from it and is clamped to the numeric range of the selected input mode. It is then cut down to the selected output width. Unsigned (single-ended) results are right-aligned and zero-extended. Signed (differential) results are right-aligned, sign-extended and one bit wider than single-ended at every width code except the full 16-bit one. A one-cycle done strobe marks each posted result, and a result is posted only once per complete averaging set.

The correction value is a plain input. Nothing inside the stage computes it.

Top module: `adc_avg_ofs`

## Requirements
- R1: While and after reset, `out_done` is 0 and `out_result` is 0 until the first result is posted. The stored averaging code resets to 0.
- R2: With `avg_code` 0, 1, 2 or 3, the stage posts exactly one result per 4, 8, 16 or 32 valid samples. `out_done` is high for one cycle, in the cycle after the clock edge that takes the set's last sample, and is low in every other cycle.
- R3: With `avg_code` 4 to 7, averaging is off and each valid sample is posted, with `out_done` high in the cycle after the sample.
- R4: The mean of N = 2^k samples is (sum + N/2) shifted right by k bits. The shift is arithmetic, so a negative differential sum rounds half upward.
- R5: `offset` is a signed 16-bit value in full-scale 16-bit units, and it is subtracted from the mean (or from the single sample).
- R6: After the subtraction, the value is clamped to [0, 65535] in single-ended mode (`diff_mode`=0) and to [-32768, 32767] in differential mode, rather than wrapping.
- R7: In single-ended mode, `res_code` 0, 1, 2 and 3 select 8, 12, 10 and 16 output bits. The output is the clamped value shifted right by (16 - bits) and zero-extended.
- R8: In differential mode, `res_code` 0, 1, 2 and 3 select 9, 13, 11 and 16 bits. The output is the clamped two's-complement value shifted right arithmetically by (16 - bits), so its upper bits copy the sign. The raw sample is read as two's complement in this mode.
- R9: A change of `avg_code` from its value in the previous cycle discards the partial sum and the sample count. A sample that is valid in the change cycle becomes the first sample of the new set.
- R10: Cycles without `in_valid` leave the partial sum and the sample count unchanged. Only valid samples count towards a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample strobe |
| in_sample | input | 16 | Raw full-scale sample code |
| avg_code | input | 3 | Averaging select: 0..3 select 4/8/16/32 samples, 4..7 turn averaging off |
| diff_mode | input | 1 | 1 selects signed differential interpretation |
| res_code | input | 2 | Output width select |
| offset | input | 16 | Signed correction subtracted from each result |
| out_done | output | 1 | One-cycle result strobe |
| out_result | output | 16 | Corrected, formatted result |

## Verification
The assertions assume that `diff_mode` and `res_code` stay constant from a set's final sample until its result is posted. They also assume that `in_valid` is only ever sampled high as a clean single-cycle strobe per sample. The stimulus changes the format controls only between sets or on samples it treats as the first of a new set, and it changes `avg_code` only rarely, so that sets normally run to completion. Directed phases then force mode changes in the middle of a set, gaps in the valid strobe, and clamping at both range limits.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
    localparam int SMP_W   = 16;
    localparam int LOG_MAX = 5;
    localparam int ACC_W   = SMP_W + LOG_MAX + 1;
    localparam int CNT_W   = LOG_MAX + 1;
    localparam int AVG_W   = SMP_W + 1;
    localparam int DIF_W   = SMP_W + 2;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
        logic [2:0]              mode;
    } acc_state_t;

    typedef struct packed {
        logic             done;
        logic [SMP_W-1:0] result;
    } out_state_t;
endpackage

// File: rtl/adc_avg_accum.sv
module adc_avg_accum
    import adc_avg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic [SMP_W-1:0]        smp,
    input  logic                    diff,
    input  logic [2:0]              avg_code,
    output logic                    set_done,
    output logic signed [AVG_W-1:0] avg_val
);
    acc_state_t st_q, st_d;

    logic                    mode_chg;
    logic [2:0]              shamt;
    logic [CNT_W-1:0]        target;
    logic signed [ACC_W-1:0] ext, base_acc, sum, half, rounded;
    logic [CNT_W-1:0]        base_cnt, next_cnt;

    always_comb begin
        st_d     = st_q;
        set_done = 1'b0;
        mode_chg = (avg_code != st_q.mode);
        shamt    = (avg_code < 3'd4) ? (avg_code + 3'd2) : 3'd0;
        target   = CNT_W'(1) << shamt;
        half     = (shamt == 3'd0) ? '0 : (ACC_W'(1) << (shamt - 3'd1));
        ext      = diff ? {{(ACC_W-SMP_W){smp[SMP_W-1]}}, smp}
                        : {{(ACC_W-SMP_W){1'b0}}, smp};
        base_acc = mode_chg ? '0 : st_q.acc;
        base_cnt = mode_chg ? '0 : st_q.cnt;
        sum      = base_acc + ext;
        next_cnt = base_cnt + CNT_W'(1);
        rounded  = (sum + half) >>> shamt;
        avg_val  = rounded[AVG_W-1:0];
        st_d.mode = avg_code;
        st_d.acc  = base_acc;
        st_d.cnt  = base_cnt;
        if (smp_vld) begin
            if (next_cnt == target) begin
                set_done  = 1'b1;
                st_d.acc  = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.acc  = sum;
                st_d.cnt  = next_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BELOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(32)); // R2
    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_code != st_q.mode) && !smp_vld |=> (st_q.cnt == '0) && (st_q.acc == '0)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && (avg_code == st_q.mode) |=> $stable(st_q.cnt) && $stable(st_q.acc)); // R10
endmodule

// File: rtl/adc_avg_post.sv
module adc_avg_post
    import adc_avg_pkg::*;
(
    input  logic signed [AVG_W-1:0] avg_val,
    input  logic [SMP_W-1:0]        offset,
    input  logic                    diff,
    input  logic [1:0]              res_code,
    output logic [SMP_W-1:0]        result
);
    localparam logic signed [DIF_W-1:0] S_MAX = DIF_W'((1 << (SMP_W-1)) - 1);
    localparam logic signed [DIF_W-1:0] S_MIN = -DIF_W'(1 << (SMP_W-1));
    localparam logic signed [DIF_W-1:0] U_MAX = DIF_W'((1 << SMP_W) - 1);

    logic signed [DIF_W-1:0] dif, sat, shifted;
    logic [4:0]              bits_se, sh;

    always_comb begin
        dif = {avg_val[AVG_W-1], avg_val} - {{2{offset[SMP_W-1]}}, offset};
        if (diff) begin
            if (dif > S_MAX)      sat = S_MAX;
            else if (dif < S_MIN) sat = S_MIN;
            else                  sat = dif;
        end else begin
            if (dif > U_MAX)      sat = U_MAX;
            else if (dif < 0)     sat = '0;
            else                  sat = dif;
        end
        case (res_code)
            2'd0:    bits_se = 5'd8;
            2'd1:    bits_se = 5'd12;
            2'd2:    bits_se = 5'd10;
            default: bits_se = 5'd16;
        endcase
        sh = 5'(SMP_W) - bits_se;
        if (diff && res_code != 2'd3) sh = sh - 5'd1;
        shifted = sat >>> sh;
        result  = shifted[SMP_W-1:0];
    end
endmodule

// File: rtl/adc_avg_ofs.sv
module adc_avg_ofs
    import adc_avg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic [2:0]       avg_code,
    input  logic             diff_mode,
    input  logic [1:0]       res_code,
    input  logic [SMP_W-1:0] offset,
    output logic             out_done,
    output logic [SMP_W-1:0] out_result
);
    out_state_t st_q, st_d;
    logic                    set_done;
    logic signed [AVG_W-1:0] avg_val;
    logic [SMP_W-1:0]        fmt_res;

    adc_avg_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (in_valid),
        .smp      (in_sample),
        .diff     (diff_mode),
        .avg_code (avg_code),
        .set_done (set_done),
        .avg_val  (avg_val)
    );

    adc_avg_post u_post (
        .avg_val  (avg_val),
        .offset   (offset),
        .diff     (diff_mode),
        .res_code (res_code),
        .result   (fmt_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = set_done;
        if (set_done) st_d.result = fmt_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_done   = st_q.done;
    assign out_result = st_q.result;

    AST_DONE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid)); // R2
    AST_BYPASS_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && avg_code[2] |=> out_done); // R3
    AST_SE8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && !diff_mode && res_code == 2'd0 && $stable(diff_mode) && $stable(res_code)
        |-> out_result[SMP_W-1:8] == '0); // R7
    AST_DIFF9_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && diff_mode && res_code == 2'd0 && $stable(diff_mode) && $stable(res_code)
        |-> (out_result[SMP_W-1:8] == '0) || (out_result[SMP_W-1:8] == '1)); // R8
endmodule

// File: tb/tb_adc_avg_ofs.sv
module tb_adc_avg_ofs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [2:0]  avg_code = '0;
    logic        diff_mode = 1'b0;
    logic [1:0]  res_code = '0;
    logic [15:0] offset = '0;
    logic        out_done;
    logic [15:0] out_result;

    int errors = 0;
    int checks = 0;

    longint m_acc = 0;
    int     m_cnt = 0;
    int     m_mode = 0;

    always #2 clk = ~clk;

    adc_avg_ofs dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .avg_code(avg_code), .diff_mode(diff_mode), .res_code(res_code),
        .offset(offset), .out_done(out_done), .out_result(out_result)
    );

    function automatic logic [15:0] fmt(longint avg, longint ofs, bit dm, int rc);
        longint d;
        int bits;
        d = avg - ofs;
        if (dm) begin
            if (d > 32767) d = 32767;
            if (d < -32768) d = -32768;
        end else begin
            if (d > 65535) d = 65535;
            if (d < 0) d = 0;
        end
        case (rc)
            0: bits = 8;
            1: bits = 12;
            2: bits = 10;
            default: bits = 16;
        endcase
        if (dm && rc != 3) bits = bits + 1;
        d = d >>> (16 - bits);
        return d[15:0];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, model it, and compare at the next falling edge.
    task automatic step(string tag, bit v, logic [15:0] s);
        bit     e_done;
        logic [15:0] e_res;
        longint ext;
        int     n;
        e_done = 0;
        e_res  = '0;
        in_valid  = v;
        in_sample = s;
        if (int'(avg_code) != m_mode) begin m_acc = 0; m_cnt = 0; end
        m_mode = int'(avg_code);
        if (v) begin
            ext = diff_mode ? longint'($signed(s)) : longint'(s);
            m_acc += ext;
            m_cnt++;
            n = (avg_code < 4) ? (1 << (avg_code + 2)) : 1;
            if (m_cnt == n) begin
                longint av;
                av = (m_acc + n / 2) >>> $clog2(n);
                e_done = 1;
                e_res = fmt(av, longint'($signed(offset)), diff_mode, int'(res_code));
                m_acc = 0;
                m_cnt = 0;
            end
        end
        @(negedge clk);
        check({tag, " done"}, {15'd0, out_done}, {15'd0, e_done});
        if (e_done) check({tag, " result"}, out_result, e_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset done", {15'd0, out_done}, 16'd0);
        check("R1 reset result", out_result, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", out_result, 16'd0);

        // R3 / R7: pass-through with every single-ended width
        avg_code = 3'd4;
        for (int r = 0; r < 4; r++) begin
            res_code = 2'(r);
            step("R3 R7 bypass", 1, 16'h1234);
            step("R3 R7 bypass", 1, 16'hFEDC);
        end
        avg_code = 3'd7;
        step("R3 code7", 1, 16'h00FF);
        // R8: differential widths
        diff_mode = 1'b1;
        for (int r = 0; r < 4; r++) begin
            res_code = 2'(r);
            step("R8 diff", 1, 16'h8001);
            step("R8 diff", 1, 16'h7FF0);
            step("R8 diff", 1, 16'hFFC0);
        end
        // R5 / R6: offset and clamping
        res_code = 2'd3;
        offset = 16'd5;
        step("R5 diff offset", 1, 16'h0100);
        step("R6 diff low clamp", 1, 16'h8000);
        offset = 16'hFFFF;
        step("R6 diff high clamp", 1, 16'h7FFF);
        diff_mode = 1'b0;
        step("R6 se high clamp", 1, 16'hFFFF);
        offset = 16'h0020;
        step("R6 se low clamp", 1, 16'h0010);
        step("R5 se offset", 1, 16'h1000);
        offset = 16'h0000;

        // R4: rounding over four samples
        avg_code = 3'd0;
        step("R9 change", 0, 16'h0);
        step("R4 round", 1, 16'd1); step("R4 round", 1, 16'd1);
        step("R4 round", 1, 16'd1); step("R4 round", 1, 16'd2);
        step("R4 round", 1, 16'd1); step("R4 round", 1, 16'd1);
        step("R4 round", 1, 16'd2); step("R4 round", 1, 16'd2);
        diff_mode = 1'b1;
        step("R4 neg", 1, 16'hFFFF); step("R4 neg", 1, 16'hFFFF);
        step("R4 neg", 1, 16'hFFFE); step("R4 neg", 1, 16'hFFFE);
        diff_mode = 1'b0;

        // R10: gaps between valid samples
        avg_code = 3'd1;
        for (int i = 0; i < 8; i++) begin
            step("R10 gap", 1, 16'(1000 * i));
            step("R10 gap", 0, 16'hFFFF);
        end
        // R9: change in the middle of a set
        step("R9 part", 1, 16'd500);
        step("R9 part", 1, 16'd500);
        avg_code = 3'd0;
        step("R9 restart", 1, 16'd40);
        step("R9 restart", 1, 16'd40);
        avg_code = 3'd2;
        step("R9 idle change", 0, 16'd0);
        for (int i = 0; i < 16; i++) step("R9 new set", 1, 16'(100 + i));
        // R2: the largest set size
        avg_code = 3'd3;
        for (int i = 0; i < 33; i++) step("R2 set32", 1, 16'(i * 2000));

        // R2 random traffic
        for (int i = 0; i < 4000; i++) begin
            if (m_cnt == 0 && ($urandom % 8) == 0) begin
                diff_mode = 1'($urandom);
                res_code  = 2'($urandom);
                offset    = ($urandom % 2) ? 16'($urandom) : 16'($urandom % 64 - 32);
            end
            if (($urandom % 60) == 0) avg_code = 3'($urandom);
            step("R2 random", ($urandom % 10) < 7, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule